// File: doc/BRIEF.md
# Two-Stage Predecoded Row Decoder

This block converts a binary row address into a one-hot wordline vector. The address is split into two or three small groups. Each group goes through its own predecoder, which is a 2-to-4 or a 3-to-8 one-hot decode. Every wordline is then formed as the AND of exactly one line taken from each predecoder bus. This is the structure a memory bank uses in place of a flat n-input decode.

The decoded vector is captured in an output register on each rising clock edge. The result is visible one edge after the address and enable are presented. When the enable is low, the register loads all zeros, so no row is driven. Parameters set the address width and the width of each group. A grouping that cannot be built from 2- and 3-bit groups in at most three slots is rejected at elaboration.

Top module: `rowdec_top`

## Requirements
- R1: When `rowEn` is high at a rising clock edge, exactly one bit of `wordLine` is set after that edge.
- R2: The bit set is index i, where i is the binary value of `rowAddr`. Group slot 0 decodes the least significant address bits, slot 1 the next bits, and slot 2 the most significant bits.
- R3: A 2-bit group value of binary 00 selects predecoder line 0 and 11 selects line 3. With two 2-bit groups, address 0x3 drives wordline 3 and address 0xC drives wordline 12.
- R4: With two 2-bit groups, the 16 wordlines cover all 4 x 4 pairs of predecoder lines. Every address 0..15 drives a distinct wordline, and each predecoder bus is one-hot.
- R5: Address 0 with `rowEn` high drives wordline 0 and no other wordline.
- R6: When `rowEn` is low at a rising clock edge, `wordLine` is all zeros after that edge, whatever the address.
- R7: While `rst_n` is low, `wordLine` is all zeros. Reset is asynchronous and active low.
- R8: 3-bit groups decode through 3-to-8 predecoders. Three 3-bit groups give the largest legal array of 512 wordlines. The following are elaboration errors: an address width that differs from the sum of the group widths, a group width other than 0, 2 or 3, an empty slot 0, or a filled slot after an empty one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the wordline register updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rowEn | input | 1 | Decode enable; when low, all wordlines are cleared |
| rowAddr | input | ADDR_W | Binary row address |
| wordLine | output | 2**ADDR_W | One-hot registered wordline vector |

## Verification
The hardest cases to reach from the ports are the highest group slot and the 512-row limit. A fault in how slot 2 is wired only appears when the upper address bits take every value together with every value of the lower bits. The bench therefore builds three instances, with 2+2, 3+2 and 3+3+3 groupings, on one shared address bus. It sweeps all 512 addresses through them, so every predecoder line of every slot is combined with every line of the other slots. Each result is compared with a single shifted bit computed in the bench.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

  typedef struct packed {
    logic load;
    logic clear;
  } rowStrobe_t;

  function automatic bit widthOk(input int w);
    return (w == 0) || (w == 2) || (w == 3);
  endfunction

  function automatic bit groupingOk(input int addrW, input int g0, input int g1, input int g2);
    bit ok;
    ok = widthOk(g0) && widthOk(g1) && widthOk(g2);
    ok = ok && (g0 != 0);
    ok = ok && !((g1 == 0) && (g2 != 0));
    ok = ok && ((g0 + g1 + g2) == addrW);
    return ok;
  endfunction

endpackage

// File: rtl/rowdec_predecode.sv
module rowdec_predecode #(
  parameter int W = 2,
  localparam int N = 1 << W
) (
  input  logic [W-1:0] sel,
  output logic [N-1:0] oneHot
);
  for (genvar j = 0; j < N; j++) begin : g_line
    assign oneHot[j] = (sel == W'(j));
  end
endmodule

// File: rtl/rowdec_ctrl.sv
module rowdec_ctrl
  import rowdec_pkg::*;
(
  input  logic       rowEn,
  output rowStrobe_t stb
);
  always_comb begin
    stb.load  = rowEn;
    stb.clear = !rowEn;
  end
endmodule

// File: rtl/rowdec_datapath.sv
module rowdec_datapath
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GRP0_W = 2,
  parameter int GRP1_W = 2,
  parameter int GRP2_W = 0,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  rowStrobe_t        stb,
  input  logic [ADDR_W-1:0] rowAddr,
  output logic [ROWS-1:0]   wordLine
);
  localparam int N0 = 1 << GRP0_W;
  localparam int N1 = 1 << GRP1_W;
  localparam int N2 = 1 << GRP2_W;
  localparam int LO1 = GRP0_W;
  localparam int LO2 = GRP0_W + GRP1_W;

  logic [N0-1:0]   pre0;
  logic [N1-1:0]   pre1;
  logic [N2-1:0]   pre2;
  logic [ROWS-1:0] wlNext;

  rowdec_predecode #(.W(GRP0_W)) i_pre0 (
    .sel   (rowAddr[GRP0_W-1:0]),
    .oneHot(pre0)
  );

  if (GRP1_W > 0) begin : g_slot1
    rowdec_predecode #(.W(GRP1_W)) i_pre1 (
      .sel   (rowAddr[LO1+GRP1_W-1:LO1]),
      .oneHot(pre1)
    );
  end else begin : g_slot1_absent
    assign pre1 = 1'b1;
  end

  if (GRP2_W > 0) begin : g_slot2
    rowdec_predecode #(.W(GRP2_W)) i_pre2 (
      .sel   (rowAddr[LO2+GRP2_W-1:LO2]),
      .oneHot(pre2)
    );
  end else begin : g_slot2_absent
    assign pre2 = 1'b1;
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam int I0 = r % N0;
    localparam int I1 = (r / N0) % N1;
    localparam int I2 = r / (N0 * N1);
    assign wlNext[r] = pre0[I0] & pre1[I1] & pre2[I2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         wordLine <= '0;
    else if (stb.clear) wordLine <= '0;
    else if (stb.load)  wordLine <= wlNext;
  end

  // R4: each predecoder bus carries exactly one active line
  a_r4_pre0_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pre0));
  a_r4_pre1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pre1));
  a_r8_pre2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(pre2));

  // R1: an enabled decode leaves exactly one wordline high
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> $onehot(wordLine));

  // R2: the active wordline sits at the address value
  a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
    stb.load |=> wordLine[$past(rowAddr)]);

  // R6: a disabled cycle leaves no wordline high
  a_r6_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
    stb.clear |=> (wordLine == '0));

  // R5: address zero selects only row zero
  a_r5_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.load && (rowAddr == '0)) |=> (wordLine[0] && $onehot(wordLine)));
endmodule

// File: rtl/rowdec_top.sv
module rowdec_top
  import rowdec_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int GRP0_W = 2,
  parameter int GRP1_W = 2,
  parameter int GRP2_W = 0,
  localparam int ROWS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rowEn,
  input  logic [ADDR_W-1:0] rowAddr,
  output logic [ROWS-1:0]   wordLine
);
  // R8: reject any grouping outside 2/3-bit groups in at most three slots
  if (!groupingOk(ADDR_W, GRP0_W, GRP1_W, GRP2_W)) begin : g_bad_grouping
    $error("rowdec_top: address width %0d cannot use groups %0d/%0d/%0d",
           ADDR_W, GRP0_W, GRP1_W, GRP2_W);
  end

  rowStrobe_t stb;

  rowdec_ctrl i_ctrl (
    .rowEn(rowEn),
    .stb  (stb)
  );

  rowdec_datapath #(
    .ADDR_W(ADDR_W),
    .GRP0_W(GRP0_W),
    .GRP1_W(GRP1_W),
    .GRP2_W(GRP2_W)
  ) i_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (stb),
    .rowAddr (rowAddr),
    .wordLine(wordLine)
  );
endmodule

// File: tb/test_rowdec_top.sv
module test_rowdec_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // entry: {enable, address[3:0], expected wordlines[15:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 4'h0, 16'h0001},   // R5
    {1'b1, 4'h3, 16'h0008},   // R3 low group 11
    {1'b1, 4'hC, 16'h1000},   // R3 upper group 11
    {1'b1, 4'hF, 16'h8000},
    {1'b0, 4'h5, 16'h0000},   // R6
    {1'b1, 4'h5, 16'h0020},
    {1'b1, 4'hA, 16'h0400},
    {1'b0, 4'hF, 16'h0000},   // R6
    {1'b1, 4'h6, 16'h0040},
    {1'b1, 4'h9, 16'h0200}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [8:0]   addr = '0;
  logic [15:0]  wl4;
  logic [31:0]  wl5;
  logic [511:0] wl9;
  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rowdec_top i_rowdec_top (
    .clk(clk), .rst_n(rst_n), .rowEn(en), .rowAddr(addr[3:0]), .wordLine(wl4)
  );

  rowdec_top #(.ADDR_W(5), .GRP0_W(3), .GRP1_W(2), .GRP2_W(0)) i_rowdec_top_5 (
    .clk(clk), .rst_n(rst_n), .rowEn(en), .rowAddr(addr[4:0]), .wordLine(wl5)
  );

  rowdec_top #(.ADDR_W(9), .GRP0_W(3), .GRP1_W(3), .GRP2_W(3)) i_rowdec_top_9 (
    .clk(clk), .rst_n(rst_n), .rowEn(en), .rowAddr(addr), .wordLine(wl9)
  );

  task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic [8:0] a);
    @(negedge clk);
    en = e;
    addr = a;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    en = 1'b1;
    addr = 9'd5;
    repeat (3) @(negedge clk);
    // R7: held in reset, all outputs stay low
    check("R7", 512'(wl4), '0);
    check("R7", 512'(wl5), '0);
    check("R7", wl9, '0);
    rst_n = 1'b1;

    // table walk on the 2+2 instance
    for (int v = 0; v < NVEC; v++) begin
      step(VEC[v][20], {5'b0, VEC[v][19:16]});
      check(VEC[v][20] ? "R2" : "R6", 512'(wl4), 512'(VEC[v][15:0]));
    end

    // R1 R2 R4 R8: exhaustive sweep through all three groupings
    for (int a = 0; a < 512; a++) begin
      step(1'b1, 9'(a));
      check("R8", wl9, 512'(1) << a);
      check("R2", 512'(wl5), 512'(1) << (a % 32));
      check("R4", 512'(wl4), 512'(1) << (a % 16));
    end

    // R6: disable clears every instance whatever the address
    step(1'b0, 9'h1FF);
    check("R6", wl9, '0);
    check("R6", 512'(wl5), '0);
    check("R6", 512'(wl4), '0);

    // R5: address zero on the largest array
    step(1'b1, 9'h000);
    check("R5", wl9, 512'(1));
    check("R5", 512'(wl4), 512'(1));

    // R7: asynchronous reset clears without a clock edge
    step(1'b1, 9'h155);
    check("R2", wl9, 512'(1) << 9'h155);
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #1;
    check("R7", wl9, '0);
    check("R7", 512'(wl4), '0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 9'h0C3);
    check("R3", 512'(wl4), 512'(1) << 3);
    check("R8", wl9, 512'(1) << 9'h0C3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule